// File: doc/BRIEF.md
# Serial Flash Host Controller

This block sits between an on-chip requester and a byte-serial flash device. It takes one operation at a time through a valid/ready request port: a read stream, a sector erase, a whole-array erase or a single-byte program. It then produces the chip-select, serial clock and serial data waveforms needed to carry that operation out. The serial clock comes from the system clock through a parameterised divider. Chip-select setup, hold and deselect gaps are also parameters counted in system clock cycles.

For a read, every byte that comes back is presented on a byte-wide strobe. For the three write-type operations, the controller keeps the write-permit pin high from the moment it accepts the request until it finishes. Once the command frame is sent, it opens a separate status frame and keeps clocking status bytes until the device reports ready. If the device does not report ready within a bounded number of status bytes, the controller gives up. A single-cycle done pulse, with an error qualifier, closes every operation.

Top module: `sflash_host`

## Requirements
- R1: After reset and whenever idle, chip-select is high, the serial clock is low, write-permit is low and `req_ready` is high.
- R2: Each frame starts with the operation's command byte. Command bytes are selected by `req_op`: 0 sends FF (read), 1 sends 20 (sector erase), 2 sends 60 (whole erase) and 3 sends 10 (program). Five bytes are always sent, MSB first. A read sends FF, the address high byte {7'b0,A16}, A15..8, A7..0 and then 00. A sector erase sends 20, the address high byte, A15..8, 00 and then D0. A whole erase sends 60, 00, 00, 00 and then D0. A program sends 10, the three address bytes and then the data byte.
- R3: The serial clock spends exactly DIV system cycles high and DIV low inside a frame. The serial data output changes only while the serial clock is low.
- R4: Chip-select is low at least GUARD cycles before the first serial clock rise and stays low at least GUARD cycles after the last fall. Between frames it is high for at least GUARD cycles.
- R5: A read returns exactly `req_len` bytes on `rd_valid`/`rd_data`, in order, from the requested address upward. The address wraps from 1FFFF to 00000. Input bytes are sampled MSB first.
- R6: Write-permit is high for the whole of every erase or program operation, from acceptance to done. It stays low for reads.
- R7: After a write-type command frame, the controller opens a new frame with command 9F and clocks status bytes until bit 0 of a status byte is 1. Only then does it signal done.
- R8: If POLL_LIMIT status bytes in a row all read busy, the frame ends and done is raised together with `done_err`. A ready status on the last allowed byte is not an error.
- R9: `req_ready` is high only when idle. A request held during an operation is not taken. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | Operation select: 0 read, 1 sector erase, 2 whole erase, 3 program |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to program |
| req_len | input | LEN_W | Number of bytes to read |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished (one cycle) |
| done_err | output | 1 | Status polling timed out (with done) |
| sck | output | 1 | Serial clock to the device |
| ce_n | output | 1 | Active-low chip-select |
| si | output | 1 | Serial data to the device |
| so | input | 1 | Serial data from the device |
| wprot | output | 1 | Write-permit, high while a write-type operation runs |

## Verification
Two things can happen on the same status byte: the device reporting ready and the poll counter reaching its limit. The bench models the device so that it stays busy for a chosen number of status bytes. One run keeps it busy for POLL_LIMIT-1 bytes, so the ready bit arrives on the final allowed byte; that run must end cleanly with `done_err` low. A second run keeps it busy for POLL_LIMIT bytes, which must end with `done_err` high. In both runs the bench counts the status bytes the device sees and compares the count with the number the requirements predict.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_PROG   = 2'd3
  } sfc_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_XFER, S_HOLD, S_GAP
  } sfc_state_e;

  localparam int          HDR_BYTES  = 5;
  localparam logic [7:0]  CMD_STATUS = 8'h9F;
  localparam logic [7:0]  CONFIRM    = 8'hD0;

  function automatic logic is_write(input sfc_op_e op);
    return op != OP_READ;
  endfunction

  // byte idx (0..4) of the command header for an operation
  function automatic logic [7:0] hdr_byte(input sfc_op_e op, input logic [2:0] idx,
                                          input logic [16:0] a, input logic [7:0] wd);
    logic [7:0] top;
    top = {7'd0, a[16]};
    case (op)
      OP_READ:   case (idx) 3'd0: return 8'hFF; 3'd1: return top;
                            3'd2: return a[15:8]; 3'd3: return a[7:0];
                            default: return 8'h00; endcase
      OP_SERASE: case (idx) 3'd0: return 8'h20; 3'd1: return top;
                            3'd2: return a[15:8]; 3'd4: return CONFIRM;
                            default: return 8'h00; endcase
      OP_CERASE: case (idx) 3'd0: return 8'h60; 3'd4: return CONFIRM;
                            default: return 8'h00; endcase
      default:   case (idx) 3'd0: return 8'h10; 3'd1: return top;
                            3'd2: return a[15:8]; 3'd3: return a[7:0];
                            default: return wd; endcase
    endcase
  endfunction

endpackage

// File: rtl/sfc_sck_gen.sv
module sfc_sck_gen #(
  parameter int DIV = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(DIV - 1));
  assign rise_evt = tick && !sck;
  assign fall_evt = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] nbyte,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       so,
  output logic       si,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sh;
  logic [6:0] rx_sh;
  logic [2:0] bitn;
  logic       byte_edge;

  assign byte_done = rise_evt && (bitn == 3'd7);
  assign byte_edge = fall_evt && (bitn == 3'd0);
  assign rx_byte   = {rx_sh, so};
  assign si        = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      bitn  <= '0;
    end else if (load) begin
      tx_sh <= nbyte;
      bitn  <= '0;
    end else begin
      if (rise_evt) begin
        rx_sh <= {rx_sh[5:0], so};
        bitn  <= bitn + 3'd1;
      end
      if (fall_evt) tx_sh <= byte_edge ? nbyte : {tx_sh[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/sflash_host.sv
module sflash_host
  import sfc_pkg::*;
#(
  parameter int DIV        = 13,
  parameter int GUARD      = 63,
  parameter int LEN_W      = 8,
  parameter int POLL_LIMIT = 131071
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [16:0]      req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             done_err,
  output logic             sck,
  output logic             ce_n,
  output logic             si,
  input  logic             so,
  output logic             wprot
);
  localparam int IDX_W = LEN_W + 2;
  localparam int GW    = $clog2(GUARD + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  sfc_state_e       st;
  sfc_op_e          op_q;
  logic [16:0]      addr_q;
  logic [7:0]       wd_q;
  logic [LEN_W-1:0] len_q;
  logic             polling, stop_q, err_q;
  logic [IDX_W-1:0] bidx;
  logic [GW-1:0]    gcnt;
  logic [PW-1:0]    pcnt;

  // named internal events
  logic       run, rise_evt, fall_evt, byte_done, load_now;
  logic       guard_end, frame_last, in_data, poll_last;
  logic [7:0] next_byte, rx_byte;

  assign req_ready  = (st == S_IDLE);
  assign run        = (st == S_XFER);
  assign guard_end  = (gcnt == GW'(GUARD - 1));
  assign load_now   = (st == S_SETUP) && guard_end;
  assign frame_last = (bidx == IDX_W'(HDR_BYTES - 1) + IDX_W'(len_q));
  assign in_data    = !polling && (op_q == OP_READ) && (bidx >= IDX_W'(HDR_BYTES));
  assign poll_last  = (pcnt == PW'(POLL_LIMIT - 1));
  assign next_byte  = polling ? ((bidx == '0) ? CMD_STATUS : 8'h00)
                    : ((bidx < IDX_W'(HDR_BYTES)) ? hdr_byte(op_q, bidx[2:0], addr_q, wd_q) : 8'h00);

  sfc_sck_gen #(.DIV(DIV)) i_sck (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sck(sck), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  sfc_shift i_shift (
    .clk(clk), .rst_n(rst_n), .load(load_now), .nbyte(next_byte),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .so(so),
    .si(si), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_READ;
      addr_q   <= '0;
      wd_q     <= '0;
      len_q    <= '0;
      polling  <= 1'b0;
      stop_q   <= 1'b0;
      err_q    <= 1'b0;
      bidx     <= '0;
      gcnt     <= '0;
      pcnt     <= '0;
      ce_n     <= 1'b1;
      wprot    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= sfc_op_e'(req_op);
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          len_q   <= req_len;
          wprot   <= is_write(sfc_op_e'(req_op));
          err_q   <= 1'b0;
          polling <= 1'b0;
          bidx    <= '0;
          gcnt    <= '0;
          ce_n    <= 1'b0;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          if (guard_end) begin
            gcnt <= '0;
            st   <= S_XFER;
          end else gcnt <= gcnt + 1'b1;
        end
        S_XFER: begin
          if (byte_done) begin
            if (bidx != '1) bidx <= bidx + 1'b1;
            if (polling) begin
              if (bidx != '0) begin
                pcnt <= pcnt + 1'b1;
                if (so) stop_q <= 1'b1;
                else if (poll_last) begin
                  stop_q <= 1'b1;
                  err_q  <= 1'b1;
                end
              end
            end else begin
              if (in_data) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_byte;
              end
              if (frame_last) stop_q <= 1'b1;
            end
          end
          if (fall_evt && stop_q) begin
            stop_q <= 1'b0;
            st     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (guard_end) begin
            gcnt <= '0;
            ce_n <= 1'b1;
            st   <= S_GAP;
          end else gcnt <= gcnt + 1'b1;
        end
        S_GAP: begin
          if (guard_end) begin
            gcnt <= '0;
            if (is_write(op_q) && !polling) begin
              polling <= 1'b1;
              bidx    <= '0;
              pcnt    <= '0;
              ce_n    <= 1'b0;
              st      <= S_SETUP;
            end else begin
              done     <= 1'b1;
              done_err <= err_q;
              wprot    <= 1'b0;
              st       <= S_IDLE;
            end
          end else gcnt <= gcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_host_chk.sv
module sfc_host_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ce_n,
  input logic sck,
  input logic si,
  input logic wprot,
  input logic rd_valid,
  input logic done,
  input logic done_err,
  input logic rise_evt,
  input logic fall_evt,
  input logic byte_done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && !sck));

  p_si_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(si));

  p_rise_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !sck);

  p_fall_from_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> sck);

  p_sck_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !ce_n);

  p_deselect_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> (!sck && !$past(sck)));

  p_rd_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(byte_done));

  p_read_unprotected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wprot);

  p_wprot_ends_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wprot) |-> done);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !ce_n);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);
endmodule

bind sflash_host sfc_host_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ce_n(ce_n), .sck(sck), .si(si), .wprot(wprot), .rd_valid(rd_valid),
  .done(done), .done_err(done_err), .rise_evt(rise_evt),
  .fall_evt(fall_evt), .byte_done(byte_done)
);

// File: tb/test_sflash_host.sv
module test_sflash_host;
  localparam int DIV = 2, GUARD = 3, LEN_W = 8, LIMIT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_op = 2'd0;
  logic [16:0]      req_addr = '0;
  logic [7:0]       req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             rd_valid, done, done_err, sck, ce_n, si, wprot;
  logic [7:0]       rd_data;
  logic             so_d = 1'b0;

  sflash_host #(.DIV(DIV), .GUARD(GUARD), .LEN_W(LEN_W), .POLL_LIMIT(LIMIT)) i_sflash_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err),
    .sck(sck), .ce_n(ce_n), .si(si), .so(so_d), .wprot(wprot)
  );

  int nvec = 0, nerr = 0, cyc = 0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    nvec++;
    if (act < lim) begin
      nerr++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_cmd[$];
  logic [7:0] exp_rd[$];

  // device model state
  int          busy_n = 0, stat_seen = 0, dev_bits = 0, dev_k = 0;
  logic [7:0]  dev_in = '0, dev_cmd = '0, dev_out = '0;
  logic [16:0] dev_addr = '0;

  function automatic logic [7:0] mem_val(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'hA5;
  endfunction

  task automatic take_byte(input logic [7:0] b);
    int hdr;
    if (dev_k == 0) begin
      dev_cmd = b;
      if (b == 8'hFF) chk_eq("R6 write-permit low in read frame", wprot, 1'b0);
      else            chk_eq("R6 write-permit high in write frame", wprot, 1'b1);
    end
    hdr = (dev_cmd == 8'h9F) ? 1 : 5;
    if (dev_k < hdr) begin
      if (exp_cmd.size() == 0) chk_eq("R2 unexpected frame byte", b, 32'hFFFF_FFFF);
      else chk_eq("R2 frame byte", b, exp_cmd.pop_front());
    end
    if (dev_cmd == 8'hFF) begin
      if (dev_k == 1) dev_addr[16]   = b[0];
      if (dev_k == 2) dev_addr[15:8] = b;
      if (dev_k == 3) dev_addr[7:0]  = b;
    end
    if (dev_cmd == 8'h9F && dev_k >= 1) stat_seen++;
  endtask

  always @(negedge ce_n) begin
    dev_bits = 0;
    dev_k    = 0;
  end

  always @(posedge sck) if (!ce_n) begin
    dev_in = {dev_in[6:0], si};
    dev_bits++;
    if (dev_bits == 8) begin
      dev_bits = 0;
      take_byte(dev_in);
      dev_k++;
    end
  end

  always @(negedge sck) if (!ce_n) begin
    if (dev_bits == 0) begin
      if (dev_cmd == 8'hFF && dev_k >= 5)      dev_out = mem_val(dev_addr + 17'(dev_k - 5));
      else if (dev_cmd == 8'h9F && dev_k >= 1) dev_out = (dev_k <= busy_n) ? 8'hFE : 8'hFF;
      else                                     dev_out = 8'h00;
    end else dev_out = {dev_out[6:0], 1'b0};
    so_d <= dev_out[7];
  end

  // read-data monitor
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_rd.size() == 0) chk_eq("R5 unexpected read byte", rd_data, 32'hFFFF_FFFF);
    else chk_eq("R5 read byte", rd_data, exp_rd.pop_front());
  end

  // waveform timing monitor
  logic p_sck = 1'b0, p_si = 1'b0, p_ce = 1'b1;
  int   hi_run = 0, lo_run = 0, ce_hi = 100, pre = 0;
  bit   first_rise = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!ce_n && p_ce) begin
      chk_ge("R4 deselect gap", ce_hi, GUARD);
      first_rise = 1'b1;
      pre = 0;
    end
    if (sck && !p_sck) begin
      if (first_rise) begin
        chk_ge("R4 select setup", pre, GUARD);
        first_rise = 1'b0;
      end else chk_eq("R3 SCK low phase", lo_run, DIV);
    end
    if (!sck && p_sck) chk_eq("R3 SCK high phase", hi_run, DIV);
    if (sck && p_sck)  chk_eq("R3 SI steady while SCK high", si, p_si);
    if (ce_n && !p_ce) chk_ge("R4 select hold", lo_run, GUARD);
    hi_run = sck ? hi_run + 1 : 0;
    lo_run = sck ? 0 : lo_run + 1;
    ce_hi  = ce_n ? ce_hi + 1 : 0;
    if (!ce_n) pre++;
    p_sck = sck; p_si = si; p_ce = ce_n;
  end

  task automatic print_summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nvec++; nerr++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<100000", cyc);
      print_summary();
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [16:0] a, input logic [7:0] wd,
                        input int len, input int busy, input bit poke);
    logic [7:0] ah;
    int exp_stat;
    bit exp_err;
    ah = {7'd0, a[16]};
    case (op)
      2'd0: begin exp_cmd.push_back(8'hFF); exp_cmd.push_back(ah); exp_cmd.push_back(a[15:8]);
                  exp_cmd.push_back(a[7:0]); exp_cmd.push_back(8'h00); end
      2'd1: begin exp_cmd.push_back(8'h20); exp_cmd.push_back(ah); exp_cmd.push_back(a[15:8]);
                  exp_cmd.push_back(8'h00); exp_cmd.push_back(8'hD0); end
      2'd2: begin exp_cmd.push_back(8'h60); exp_cmd.push_back(8'h00); exp_cmd.push_back(8'h00);
                  exp_cmd.push_back(8'h00); exp_cmd.push_back(8'hD0); end
      default: begin exp_cmd.push_back(8'h10); exp_cmd.push_back(ah); exp_cmd.push_back(a[15:8]);
                  exp_cmd.push_back(a[7:0]); exp_cmd.push_back(wd); end
    endcase
    if (op != 2'd0) exp_cmd.push_back(8'h9F);
    for (int i = 0; i < len; i++) exp_rd.push_back(mem_val(a + 17'(i)));
    exp_stat  = (op == 2'd0) ? 0 : ((busy < LIMIT) ? busy + 1 : LIMIT);
    exp_err   = (op != 2'd0) && (busy >= LIMIT);
    busy_n    = busy;
    stat_seen = 0;

    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_len = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R9 accepted request selects device", ce_n, 1'b0);
    chk_eq("R9 ready drops while busy", req_ready, 1'b0);
    chk_eq("R6 write-permit after accept", wprot, (op != 2'd0));
    if (poke) begin
      repeat (3) @(negedge clk);
      req_op = 2'd2; req_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk_eq("R9 no ready during operation", req_ready, 1'b0);
      end
      req_valid = 1'b0; req_op = op;
    end
    while (!done) @(negedge clk);
    chk_eq("R8 error flag at done", done_err, exp_err);
    chk_eq("R7 status bytes clocked", stat_seen, exp_stat);
    chk_eq("R2 all frame bytes seen", exp_cmd.size(), 0);
    chk_eq("R5 all read bytes returned", exp_rd.size(), 0);
    chk_eq("R6 write-permit low at done", wprot, 1'b0);
    @(negedge clk);
    chk_eq("R9 done lasts one cycle", done, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 reset chip-select", ce_n, 1'b1);
    chk_eq("R1 reset clock", sck, 1'b0);
    chk_eq("R1 reset write-permit", wprot, 1'b0);
    chk_eq("R1 reset ready", req_ready, 1'b1);
    chk_eq("R9 reset done", done, 1'b0);

    run_op(2'd0, 17'h00010, 8'h00, 4, 0, 1'b1);     // R5 plain read, R9 held request
    repeat (20) @(negedge clk);
    chk_eq("R9 held request not taken later", ce_n, 1'b1);
    chk_eq("R1 idle after read", req_ready, 1'b1);
    run_op(2'd0, 17'h1FFFE, 8'h00, 4, 0, 1'b0);     // R5 wrap at top
    run_op(2'd3, 17'h0ABCD, 8'h3C, 0, 2, 1'b0);     // R7 program, two busy polls
    run_op(2'd1, 17'h12345, 8'h00, 0, 0, 1'b0);     // R2 sector erase, ready at once
    run_op(2'd2, 17'h00000, 8'h00, 0, LIMIT - 1, 1'b0); // R8 ready on last allowed byte
    run_op(2'd3, 17'h00777, 8'h81, 0, LIMIT, 1'b0);     // R8 timeout
    run_op(2'd0, 17'h1FFFF, 8'h00, 1, 0, 1'b0);     // R5 single byte at top
    repeat (10) @(negedge clk);
    print_summary();
    $finish;
  end
endmodule